// File: doc/BRIEF.md
# I2C Serial Clock Waveform Generator

This block produces the serial clock for an I2C bus master. It does not use one symmetric divide-by-N. The high and the low phase of SCL each have their own 8-bit divider, and both share a power-of-two prescaler exponent. Each phase lasts `divider * 2^exponent + 3` system clock cycles, so the duty cycle can be trimmed to meet the bus's minimum high and low times. A byte engine sits beside the block and drives SDA. It uses two one-cycle strobes from the generator. The first marks the SCL rising edge, where SDA is sampled. The second marks the middle of each low phase, where SDA may change.

A transfer begins with a start request while the generator is idle. The block marks the moment SDA must fall with SCL still high. It holds SCL high for one high phase, then clocks low and high phases until a stop is requested. The stop takes effect at the end of the current high phase. After it, one more low phase lets SDA settle low, then a final high phase runs. A stop strobe in the last cycle of that phase tells the engine to release SDA while SCL is high. The block then returns to idle with SCL released.

The configuration word is captured only while the generator is idle. A new setting therefore applies to the next transfer and never cuts a bit short. The open-drain pad and the byte sequencing are outside this block.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, and whenever no transfer is running, `busy` is 0, `scl_oe` is 0, `scl_level` is 1 and all four strobes are 0.
- R2: A `start_req` seen while idle makes `busy` 1 on the next cycle. In that same cycle `start_stb` pulses for one cycle with SCL high. SCL stays high for exactly the high-phase length, counting that cycle, before its first low phase.
- R3: Every low phase (`scl_oe` = 1) lasts exactly `L * 2^E + 3` cycles. L is configuration bits 7:0 and E is configuration bits 18:16.
- R4: Every high phase inside a transfer lasts exactly `H * 2^E + 3` cycles. H is configuration bits 15:8.
- R5: `sample_stb` pulses for one cycle in the first cycle of each data high phase, which is the cycle SCL rises. A transfer stopped after N data bits produces exactly N such pulses.
- R6: `change_stb` pulses once per low phase, in the cycle with zero-based index floor(low length / 2). A transfer with N data bits has N+1 low phases.
- R7: A `stop_req` received during a transfer takes effect at the end of the current high phase. One low phase follows, then a high phase of the high-phase length. `stop_stb` pulses in the last cycle of that high phase, and the block is idle on the next cycle.
- R8: The configuration is captured only while idle. A change to `cfg_word` during a transfer leaves that transfer's phase lengths unchanged.
- R9: A `start_req` during a transfer is ignored and produces no second `start_stb`. A `stop_req` while idle is ignored, and SCL stays released.
- R10: The word 0x047575 gives high and low phases of 1875 cycles each.
- R11: At most one of the four strobes is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 19 | Low divider [7:0], high divider [15:8], prescaler exponent [18:16] |
| start_req | input | 1 | One-cycle request to begin a transfer |
| stop_req | input | 1 | One-cycle request to end the transfer after the current bit |
| busy | output | 1 | A transfer is in progress |
| scl_oe | output | 1 | 1 = pull SCL low |
| scl_level | output | 1 | Intended SCL level |
| sample_stb | output | 1 | SCL rising edge of a data bit |
| change_stb | output | 1 | Middle of a low phase |
| start_stb | output | 1 | Drive SDA low now (START condition) |
| stop_stb | output | 1 | Release SDA now (STOP condition) |

## Verification
Suppose the phase counter or the captured configuration goes wrong. The first phase boundary then comes early or late, and the bench measures every SCL run length against the value it computes itself, so the error shows within one phase. A wrong sequencer state shows on the next strobe. It appears as a sample pulse that does not line up with a rising edge, a change pulse away from the low-phase middle, or a wrong strobe count for the number of bits. A stop-handling fault shows as a busy flag that does not drop on the cycle after the stop strobe.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    localparam int DIV_W   = 8;
    localparam int EXP_W   = 3;
    localparam int CFG_W   = 2 * DIV_W + EXP_W;
    localparam int MAX_SH  = (1 << EXP_W) - 1;
    localparam int PER_W   = DIV_W + MAX_SH + 1;
    localparam int OVERHEAD = 3;

    typedef logic [PER_W-1:0] per_t;

    // Field order is fixed by the configuration word layout.
    typedef struct packed {
        logic [EXP_W-1:0] expo;
        logic [DIV_W-1:0] hdiv;
        logic [DIV_W-1:0] ldiv;
    } scl_cfg_t;

    typedef struct packed {
        per_t high_len;
        per_t low_len;
        per_t low_mid;
    } scl_times_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_LOW,
        ST_HIGH,
        ST_PRESTOP,
        ST_STOP
    } scl_state_e;

    function automatic per_t phase_cycles(input logic [DIV_W-1:0] d,
                                          input logic [EXP_W-1:0] e);
        per_t wide;
        wide = {{(PER_W-DIV_W){1'b0}}, d};
        return (wide << e) + per_t'(OVERHEAD);
    endfunction

    function automatic logic is_low_phase(input scl_state_e s);
        return (s == ST_LOW) || (s == ST_PRESTOP);
    endfunction

endpackage

// File: rtl/scl_cfg_hold.sv
module scl_cfg_hold
    import scl_gen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hold_open,
    input  logic [CFG_W-1:0]  cfg_in,
    output scl_times_t        times
);

    scl_cfg_t cfg_q;

    // Capture only while idle so a running transfer keeps its timing.
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (hold_open) begin
            cfg_q <= scl_cfg_t'(cfg_in);
        end
    end

    always_comb begin
        times.high_len = phase_cycles(cfg_q.hdiv, cfg_q.expo);
        times.low_len  = phase_cycles(cfg_q.ldiv, cfg_q.expo);
        times.low_mid  = times.low_len >> 1;
    end

endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] len,
    input  logic [W-1:0] mid,
    output logic         at_first,
    output logic         at_mid,
    output logic         at_end
);

    logic [W-1:0] cnt_q;

    assign at_first = run && (cnt_q == '0);
    assign at_mid   = run && (cnt_q == mid);
    assign at_end   = run && (cnt_q == len - W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!run || at_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + W'(1);
        end
    end

endmodule

// File: rtl/scl_seq_fsm.sv
module scl_seq_fsm
    import scl_gen_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_req,
    input  logic       stop_req,
    input  logic       phase_end,
    output scl_state_e state
);

    scl_state_e state_q, state_d;
    logic       pend_q, pend_d;
    logic       want_stop;

    assign state     = state_q;
    assign want_stop = pend_q || stop_req;

    always_comb begin
        state_d = state_q;
        pend_d  = pend_q;
        unique case (state_q)
            ST_IDLE: begin
                pend_d = 1'b0;
                if (start_req) state_d = ST_START;
            end
            ST_START: begin
                pend_d = want_stop;
                if (phase_end) state_d = ST_LOW;
            end
            ST_LOW: begin
                pend_d = want_stop;
                if (phase_end) state_d = ST_HIGH;
            end
            ST_HIGH: begin
                pend_d = want_stop;
                if (phase_end) begin
                    state_d = want_stop ? ST_PRESTOP : ST_LOW;
                    pend_d  = 1'b0;
                end
            end
            ST_PRESTOP: begin
                pend_d = 1'b0;
                if (phase_end) state_d = ST_STOP;
            end
            ST_STOP: begin
                pend_d = 1'b0;
                if (phase_end) state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
                pend_d  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_gen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             start_req,
    input  logic             stop_req,
    output logic             busy,
    output logic             scl_oe,
    output logic             scl_level,
    output logic             sample_stb,
    output logic             change_stb,
    output logic             start_stb,
    output logic             stop_stb
);

    scl_state_e state;
    scl_times_t times;
    per_t       cur_len;
    logic       low_ph;
    logic       at_first, at_mid, at_end;

    assign busy   = (state != ST_IDLE);
    assign low_ph = is_low_phase(state);

    scl_cfg_hold u_cfg (
        .clk       (clk),
        .rst       (rst),
        .hold_open (!busy),
        .cfg_in    (cfg_word),
        .times     (times)
    );

    assign cur_len = low_ph ? times.low_len : times.high_len;

    scl_phase_ctr #(.W(PER_W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .run      (busy),
        .len      (cur_len),
        .mid      (times.low_mid),
        .at_first (at_first),
        .at_mid   (at_mid),
        .at_end   (at_end)
    );

    scl_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start_req (start_req),
        .stop_req  (stop_req),
        .phase_end (at_end),
        .state     (state)
    );

    assign scl_oe     = low_ph;
    assign scl_level  = !low_ph;
    assign sample_stb = (state == ST_HIGH)  && at_first;
    assign start_stb  = (state == ST_START) && at_first;
    assign stop_stb   = (state == ST_STOP)  && at_end;
    assign change_stb = low_ph && at_mid;

endmodule

// File: rtl/scl_timing_gen_chk.sv
module scl_timing_gen_chk
    import scl_gen_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [CFG_W-1:0] cfg_word,
    input logic             start_req,
    input logic             busy,
    input logic             scl_oe,
    input logic             scl_level,
    input logic             sample_stb,
    input logic             change_stb,
    input logic             start_stb,
    input logic             stop_stb
);

    scl_cfg_t          ref_cfg;
    logic [PER_W:0]    low_run;
    logic [PER_W:0]    ref_low;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_cfg <= '0;
            low_run <= '0;
        end else begin
            if (!busy) ref_cfg <= scl_cfg_t'(cfg_word);
            low_run <= scl_oe ? low_run + 1'b1 : '0;
        end
    end

    assign ref_low = {1'b0, phase_cycles(ref_cfg.ldiv, ref_cfg.expo)};

    assert_idle_released_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!scl_oe && scl_level && !sample_stb && !change_stb));

    assert_start_from_idle_R2: assert property (@(posedge clk) disable iff (rst)
        start_stb |-> (scl_level && !$past(busy)));

    assert_low_length_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(scl_oe) |-> (low_run == ref_low));

    assert_sample_on_rise_R5: assert property (@(posedge clk) disable iff (rst)
        sample_stb |-> (scl_level && $past(scl_oe)));

    assert_change_in_low_R6: assert property (@(posedge clk) disable iff (rst)
        change_stb |-> scl_oe);

    assert_stop_to_idle_R7: assert property (@(posedge clk) disable iff (rst)
        stop_stb |=> !busy);

    assert_no_restart_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && start_req) |=> !start_stb);

    assert_one_strobe_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sample_stb, change_stb, start_stb, stop_stb}));

endmodule

bind scl_timing_gen scl_timing_gen_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_word   (cfg_word),
    .start_req  (start_req),
    .busy       (busy),
    .scl_oe     (scl_oe),
    .scl_level  (scl_level),
    .sample_stb (sample_stb),
    .change_stb (change_stb),
    .start_stb  (start_stb),
    .stop_stb   (stop_stb)
);

// File: tb/scl_timing_gen_tb.sv
module scl_timing_gen_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [18:0] cfg_word = '0;
    logic        start_req = 1'b0;
    logic        stop_req = 1'b0;
    logic        busy, scl_oe, scl_level;
    logic        sample_stb, change_stb, start_stb, stop_stb;

    always #4 clk = ~clk;

    scl_timing_gen u_dut (
        .clk        (clk),
        .rst        (rst),
        .cfg_word   (cfg_word),
        .start_req  (start_req),
        .stop_req   (stop_req),
        .busy       (busy),
        .scl_oe     (scl_oe),
        .scl_level  (scl_level),
        .sample_stb (sample_stb),
        .change_stb (change_stb),
        .start_stb  (start_stb),
        .stop_stb   (stop_stb)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int exp_th, exp_tl;
    int hi_run, lo_run;
    bit in_xfer = 0;
    bit prev_stop = 0;
    int n_start, n_sample, n_change, n_stop;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // Run-length monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_stop)
                chk(!busy && !scl_oe && scl_level, "R7 idle after stop", int'(busy), 0);
            prev_stop = stop_stb;
            if (start_stb) begin
                chk(!in_xfer && scl_level, "R2 start only from idle", int'(in_xfer), 0);
                n_start++;
                in_xfer = 1;
                hi_run = 1;
                lo_run = 0;
            end else if (in_xfer) begin
                if (scl_oe) begin
                    if (hi_run > 0) begin
                        chk(hi_run == exp_th, "R2 R4 high length", hi_run, exp_th);
                        hi_run = 0;
                    end
                    if (change_stb) begin
                        chk(lo_run == exp_tl / 2, "R6 change index", lo_run, exp_tl / 2);
                        n_change++;
                    end
                    lo_run++;
                end else begin
                    if (lo_run > 0) begin
                        chk(lo_run == exp_tl, "R3 low length", lo_run, exp_tl);
                        lo_run = 0;
                    end
                    if (sample_stb) begin
                        chk(hi_run == 0, "R5 sample at rise", hi_run, 0);
                        n_sample++;
                    end
                    hi_run++;
                    if (stop_stb) begin
                        chk(hi_run == exp_th, "R7 stop setup length", hi_run, exp_th);
                        n_stop++;
                        in_xfer = 0;
                        hi_run = 0;
                    end
                end
            end
        end
    end

    task automatic run_xfer(input int e, input int hd, input int ld,
                            input int nbits, input bit disturb);
        @(negedge clk);
        cfg_word = {e[2:0], hd[7:0], ld[7:0]};
        exp_th = (hd << e) + 3;
        exp_tl = (ld << e) + 3;
        n_start = 0; n_sample = 0; n_change = 0; n_stop = 0;
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        if (disturb) begin
            // R8: new word mid-transfer; R9: second start while busy
            cfg_word = 19'h7_FFFF;
            start_req = 1'b1;
            @(negedge clk);
            start_req = 1'b0;
        end
        while (n_sample < nbits) @(negedge clk);
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        while (n_stop == 0) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        chk(n_start == 1, "R9 single start strobe", n_start, 1);
        chk(n_sample == nbits, "R5 sample count", n_sample, nbits);
        chk(n_change == nbits + 1, "R6 change count", n_change, nbits + 1);
        chk(n_stop == 1, "R7 stop strobe count", n_stop, 1);
        chk(!busy && !scl_oe && scl_level, "R1 idle after transfer", int'(busy), 0);
    endtask

    initial begin
        int hds[3];
        int lds[3];
        int idx;
        hds = '{0, 1, 5};
        lds = '{0, 2, 7};

        repeat (3) @(negedge clk);
        chk(!busy && !scl_oe && scl_level, "R1 reset state", int'(scl_oe), 0);
        chk(!(sample_stb || change_stb || start_stb || stop_stb), "R1 no strobes in reset",
            int'(start_stb), 0);
        rst = 1'b0;
        repeat (4) begin
            @(negedge clk);
            chk(!busy && scl_level && !start_stb, "R1 idle released", int'(busy), 0);
        end

        idx = 0;
        for (int e = 0; e < 3; e++) begin
            for (int h = 0; h < 3; h++) begin
                for (int l = 0; l < 3; l++) begin
                    run_xfer(e, hds[h], lds[l], 1 + (idx % 3), (idx % 4) == 1);
                    idx++;
                end
            end
        end

        // R9: stop while idle has no effect
        @(negedge clk);
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        repeat (6) begin
            @(negedge clk);
            chk(!busy && !scl_oe && !stop_stb, "R9 stop ignored when idle", int'(busy), 0);
        end

        // R10: reference word 0x047575, 1875 cycles per phase
        run_xfer(4, 117, 117, 1, 1'b0);
        chk(exp_th == 1875 && exp_tl == 1875, "R10 reference period", exp_th, 1875);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual 1 expected 0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule